// File: doc/BRIEF.md
# Multi-Rate System Counter with Frequency Table

This block keeps a 64-bit free-running time count that is always expressed in units of a base tick rate, even when the count is stepped less often to save switching activity. A small table of 32-bit frequency values, in Hz, sits behind a simple register port. Entry 0 holds the base rate. The table ends at the first zero entry. A mode request picks one entry. From then on the counter steps once every `base/selected` base ticks and adds that same ratio on each step, so the count keeps its scale in every mode.

A request is checked when it arrives. The index must lie before the zero terminator, and its entry must be an exact power-of-two divisor of the base. An accepted request waits for the next update boundary. At that boundary the prescaler restarts under the new ratio. A rejected request leaves the active mode alone and sets a sticky error flag. A build parameter makes the table either a writable register file, whose contents are undefined after power-up and must be loaded by software, or a constant table fixed at build time.

Top module: `mrate_counter`

## Requirements
- R1: After reset, `count` is 0, `active_mode` is 0 (base rate) and `mode_err` is 0.
- R2: In mode 0 with `cnt_en` high, `count` rises by exactly 1 for every cycle in which `base_tick` is high.
- R3: While `cnt_en` is low, neither `count` nor the prescaler advances. After the enable returns, an update needs only the base ticks that were still missing from the period that was interrupted.
- R4: In a mode whose entry equals base/2^k, `count` rises by 2^k on every 2^k-th enabled base tick and holds on the other ticks.
- R5: An accepted mode request takes effect only at the next update boundary. The update on that boundary still uses the old step. The prescaler then restarts from zero, and `count` never decreases.
- R6: A request for an index at or after the first zero entry, or at or beyond NUM_ENTRIES, is rejected. `active_mode` is unchanged and `mode_err` becomes 1 and stays 1 until reset, even if later requests are accepted.
- R7: A request for a nonzero entry that is not base/2^k for any k from 0 to 31 (for example 300000 with a base of 1000000) is rejected in the same way as in R6.
- R8: Table entry n is read and, in the writable build, written at byte offset 0x20 + 4·n. Reads are combinational from `reg_addr`.
- R9: A read from any offset that maps to no entry (below 0x20, not a multiple of 4, or at or beyond 0x20 + 4·NUM_ENTRIES) returns 0.
- R10: In the read-only build, writes have no effect and every entry reads back its build-time constant.
- R11: `active_mode` shows the index of the mode in force. It changes only in a cycle in which `count` also changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | One-cycle enable at the base rate |
| cnt_en | input | 1 | Counter enable; low holds the prescaler and the count |
| mode_req | input | 1 | Strobe: request the mode given on `mode_idx` |
| mode_idx | input | IDX_W (3) | Requested table index |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| count | output | 64 | Count in base-rate units |
| active_mode | output | IDX_W (3) | Index of the mode in force |
| mode_err | output | 1 | Sticky flag for a rejected mode request |

## Verification
A wrong step size or a wrong prescaler phase shows up on `count` at the first update after a mode change. That is at most 2^k base ticks later, and the bench checks the count both on the boundary tick and on the tick just before it. A stale or lost pending mode shows up on `active_mode` at that same boundary. A prescaler that keeps running while `cnt_en` is low shows up as an update that arrives early on the first tick after re-enable. An error flag that fails to stick, or a table decode that is wrong, is seen in the next cycle or the next combinational read.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   // byte offset of the first frequency entry and the spacing between entries
   localparam int unsigned TBL_OFFSET = 32'h20;
   localparam int unsigned TBL_STRIDE = 4;

   function automatic int unsigned entry_offset(input int unsigned n);
      return TBL_OFFSET + TBL_STRIDE * n;
   endfunction
endpackage

// File: rtl/mrc_table.sv
module mrc_table
   import mrc_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned FREQ_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter bit          WRITABLE    = 1'b1,
   parameter logic [NUM_ENTRIES-1:0][FREQ_W-1:0] ROM_INIT = '0
) (
   input  logic                               clk,
   input  logic                               wr,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [FREQ_W-1:0]                  wdata,
   output logic [FREQ_W-1:0]                  rdata,
   output logic [NUM_ENTRIES-1:0][FREQ_W-1:0] entries
);
   if (WRITABLE) begin : g_rw
      // no reset: contents are undefined until software loads them
      logic [NUM_ENTRIES-1:0][FREQ_W-1:0] mem;
      always_ff @(posedge clk) begin
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (wr && addr == ADDR_W'(entry_offset(i)))
               mem[i] <= wdata;
         end
      end
      assign entries = mem;
   end else begin : g_ro
      logic unused_wr_side;
      assign unused_wr_side = ^{clk, wr, wdata};
      assign entries = ROM_INIT;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (addr == ADDR_W'(entry_offset(i)))
            rdata = entries[i];
      end
   end
endmodule

// File: rtl/mrc_mode_check.sv
module mrc_mode_check #(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned FREQ_W      = 32,
   parameter int unsigned IDX_W       = 3,
   localparam int unsigned SH_W       = $clog2(FREQ_W)
) (
   input  logic [NUM_ENTRIES-1:0][FREQ_W-1:0] entries,
   input  logic [IDX_W-1:0]                   idx,
   output logic                               ok,
   output logic [SH_W-1:0]                    shift
);
   logic              in_range;
   logic              chain_ok;
   logic [FREQ_W-1:0] sel;
   logic              ratio_ok;

   // range and terminator: every entry up to and including idx must be nonzero
   always_comb begin
      in_range = 1'b0;
      chain_ok = 1'b1;
      sel      = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (idx == IDX_W'(i)) begin
            in_range = 1'b1;
            sel      = entries[i];
         end
         if (IDX_W'(i) <= idx && entries[i] == '0)
            chain_ok = 1'b0;
      end
   end

   // power-of-two divisor search without a divider
   logic [FREQ_W-1:0] hit;
   for (genvar k = 0; k < FREQ_W; k++) begin : g_ratio
      assign hit[k] = (sel != '0) &&
                      (({{FREQ_W{1'b0}}, sel} << k) == {{FREQ_W{1'b0}}, entries[0]});
   end

   always_comb begin
      ratio_ok = 1'b0;
      shift    = '0;
      for (int k = FREQ_W - 1; k >= 0; k--) begin
         if (hit[k]) begin
            ratio_ok = 1'b1;
            shift    = SH_W'(k);
         end
      end
   end

   assign ok = in_range && chain_ok && ratio_ok;
endmodule

// File: rtl/mrc_divider.sv
module mrc_divider #(
   parameter int unsigned FREQ_W = 32,
   localparam int unsigned SH_W  = $clog2(FREQ_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [SH_W-1:0] shift,
   output logic            upd
);
   logic [FREQ_W-1:0] presc;
   logic [FREQ_W-1:0] last;

   assign last = FREQ_W'(({1'b0, {FREQ_W{1'b0}}} | (FREQ_W+1)'(1)) << shift) - FREQ_W'(1);
   assign upd  = tick && (presc == last);

   // wrap clears the prescaler; a mode change is only applied on a wrap,
   // so every new mode starts its first period from zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    presc <= '0;
      else if (upd)  presc <= '0;
      else if (tick) presc <= presc + FREQ_W'(1);
   end
endmodule

// File: rtl/mrate_counter.sv
module mrate_counter
   import mrc_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned FREQ_W      = 32,
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned ADDR_W      = 8,
   parameter bit          WRITABLE    = 1'b1,
   parameter logic [NUM_ENTRIES-1:0][FREQ_W-1:0] ROM_INIT =
      {32'd0, 32'd250000, 32'd500000, 32'd1000000},
   localparam int unsigned IDX_W = $clog2(NUM_ENTRIES + 1),
   localparam int unsigned SH_W  = $clog2(FREQ_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              cnt_en,
   input  logic              mode_req,
   input  logic [IDX_W-1:0]  mode_idx,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [CNT_W-1:0]  count,
   output logic [IDX_W-1:0]  active_mode,
   output logic              mode_err
);
   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("mrate_counter: NUM_ENTRIES must be at least 2");
   end
   if (FREQ_W != 32) begin : g_bad_width
      $error("mrate_counter: frequency entries are 32 bits wide");
   end
   if (CNT_W < FREQ_W) begin : g_bad_cnt
      $error("mrate_counter: CNT_W must cover the largest step");
   end
   if (entry_offset(NUM_ENTRIES) > (1 << ADDR_W)) begin : g_bad_addr
      $error("mrate_counter: ADDR_W too narrow for the table");
   end

   logic [NUM_ENTRIES-1:0][FREQ_W-1:0] entries;
   logic                               req_ok;
   logic [SH_W-1:0]                    req_shift;
   logic                               upd;

   logic [SH_W-1:0]  act_shift;
   logic             pend_vld;
   logic [IDX_W-1:0] pend_idx;
   logic [SH_W-1:0]  pend_shift;

   mrc_table #(
      .NUM_ENTRIES(NUM_ENTRIES), .FREQ_W(FREQ_W), .ADDR_W(ADDR_W),
      .WRITABLE(WRITABLE), .ROM_INIT(ROM_INIT)
   ) u_table (
      .clk(clk), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .entries(entries)
   );

   mrc_mode_check #(
      .NUM_ENTRIES(NUM_ENTRIES), .FREQ_W(FREQ_W), .IDX_W(IDX_W)
   ) u_check (
      .entries(entries), .idx(mode_idx), .ok(req_ok), .shift(req_shift)
   );

   mrc_divider #(.FREQ_W(FREQ_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(base_tick && cnt_en),
      .shift(act_shift), .upd(upd)
   );

   // mode registers: pending request applied on the next update boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_mode <= '0;
         act_shift   <= '0;
         pend_vld    <= 1'b0;
         pend_idx    <= '0;
         pend_shift  <= '0;
         mode_err    <= 1'b0;
      end else begin
         if (upd && pend_vld) begin
            active_mode <= pend_idx;
            act_shift   <= pend_shift;
            pend_vld    <= 1'b0;
         end
         if (mode_req && req_ok) begin
            pend_vld   <= 1'b1;
            pend_idx   <= mode_idx;
            pend_shift <= req_shift;
         end
         if (mode_req && !req_ok)
            mode_err <= 1'b1;
      end
   end

   // count in base-rate units: step of 2^shift per update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (upd) count <= count + (CNT_W'(1) << act_shift);
   end
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             base_tick,
   input logic             cnt_en,
   input logic [CNT_W-1:0] count,
   input logic [IDX_W-1:0] active_mode,
   input logic             mode_err
);
   a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(count));

   a_r4_no_tick_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      !base_tick |=> $stable(count));

   a_r4_pow2_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> $countones(count - $past(count)) == 1);

   a_r5_never_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> count > $past(count));

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> mode_err);

   a_r11_mode_on_update: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_mode) |-> !$stable(count));
endmodule

bind mrate_counter mrc_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cnt_en(cnt_en),
   .count(count), .active_mode(active_mode), .mode_err(mode_err)
);

// File: tb/mrate_counter_test.sv
module mrate_counter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_tick = 1'b0;
   logic        cnt_en = 1'b0;
   logic        mode_req = 1'b0;
   logic [2:0]  mode_idx = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, ro_rdata;
   logic [63:0] count, ro_count;
   logic [2:0]  active_mode, ro_mode;
   logic        mode_err, ro_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mrate_counter uut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cnt_en(cnt_en),
      .mode_req(mode_req), .mode_idx(mode_idx), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .count(count), .active_mode(active_mode), .mode_err(mode_err)
   );

   mrate_counter #(.WRITABLE(1'b0)) uut_ro (
      .clk(clk), .rst_n(rst_n), .base_tick(1'b0), .cnt_en(1'b0),
      .mode_req(1'b0), .mode_idx(3'd0), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(ro_rdata),
      .count(ro_count), .active_mode(ro_mode), .mode_err(ro_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock: inputs driven at the falling edge, outputs sampled just after the rising edge
   task automatic cyc(input logic bt, input logic rq, input logic [2:0] idx);
      @(negedge clk);
      base_tick = bt; mode_req = rq; mode_idx = idx;
      @(posedge clk); #1;
      base_tick = 1'b0; mode_req = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a,
                           input logic [31:0] exp, input bit ro);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, ro ? ro_rdata : reg_rdata, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cnt_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check("R1 count", count, 0);
      check("R1 mode", active_mode, 0);
      check("R1 err", mode_err, 0);
   endtask

   task automatic t_table();
      wr(8'h20, 32'd1000000);
      wr(8'h24, 32'd500000);
      wr(8'h28, 32'd250000);
      wr(8'h2C, 32'd300000);
      rd_check("R8 entry0", 8'h20, 32'd1000000, 0);
      rd_check("R8 entry1", 8'h24, 32'd500000, 0);
      rd_check("R8 entry3", 8'h2C, 32'd300000, 0);
      rd_check("R9 low offset", 8'h00, 32'd0, 0);
      rd_check("R9 below table", 8'h1C, 32'd0, 0);
      rd_check("R9 misaligned", 8'h22, 32'd0, 0);
      rd_check("R9 past table", 8'h30, 32'd0, 0);
   endtask

   task automatic t_readonly();
      wr(8'h20, 32'd5);
      rd_check("R8 rw write", 8'h20, 32'd5, 0);
      rd_check("R10 ro entry0 kept", 8'h20, 32'd1000000, 1);
      rd_check("R10 ro entry2", 8'h28, 32'd250000, 1);
      rd_check("R10 ro terminator", 8'h2C, 32'd0, 1);
      wr(8'h20, 32'd1000000);
   endtask

   task automatic t_base_rate();
      cnt_en = 1'b1;
      ticks(5);
      check("R2 base rate", count, 5);
      cyc(1'b0, 1'b0, 3'd0);
      check("R2 no tick", count, 5);
   endtask

   task automatic t_disable();
      cnt_en = 1'b0;
      ticks(3);
      check("R3 held", count, 5);
      cnt_en = 1'b1;
   endtask

   task automatic t_mode_change();
      cyc(1'b0, 1'b1, 3'd2);
      check("R5 not yet applied", active_mode, 0);
      ticks(1);
      check("R5 old step on boundary", count, 6);
      check("R11 mode 2 active", active_mode, 2);
      ticks(3);
      check("R4 ratio4 holds", count, 6);
      ticks(1);
      check("R4 ratio4 step", count, 10);
      ticks(1);
      cyc(1'b0, 1'b1, 3'd1);
      ticks(2);
      check("R5 waits for boundary cnt", count, 10);
      check("R5 waits for boundary mode", active_mode, 2);
      ticks(1);
      check("R5 boundary step", count, 14);
      check("R11 mode 1 active", active_mode, 1);
      ticks(2);
      check("R4 ratio2 step", count, 16);
      ticks(1);
      cnt_en = 1'b0;
      ticks(3);
      cnt_en = 1'b1;
      check("R3 held mid period", count, 16);
      ticks(1);
      check("R3 prescaler kept phase", count, 18);
   endtask

   task automatic t_bad_ratio();
      cyc(1'b0, 1'b1, 3'd3);
      check("R7 err set", mode_err, 1);
      ticks(2);
      check("R7 mode kept", active_mode, 1);
      check("R7 rate kept", count, 20);
   endtask

   task automatic t_terminator();
      do_reset();
      #1;
      check("R1 err cleared", mode_err, 0);
      wr(8'h28, 32'd0);
      wr(8'h2C, 32'd125000);
      cnt_en = 1'b1;
      cyc(1'b0, 1'b1, 3'd3);
      check("R6 past terminator err", mode_err, 1);
      ticks(2);
      check("R6 mode kept", active_mode, 0);
      check("R6 base rate kept", count, 2);
      do_reset();
      cnt_en = 1'b1;
      cyc(1'b0, 1'b1, 3'd4);
      check("R6 beyond depth err", mode_err, 1);
      cyc(1'b0, 1'b1, 3'd1);
      ticks(1);
      check("R6 valid after error", active_mode, 1);
      check("R6 err sticky", mode_err, 1);
   endtask

   initial begin
      t_reset();
      t_table();
      t_readonly();
      t_base_rate();
      t_disable();
      t_mode_change();
      t_bad_ratio();
      t_terminator();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule